// File: doc/BRIEF.md
# Machine Check Exception Sequencer

This block decides whether an error reported by the core becomes a machine check interrupt. There are two error sources. The first is a bus error seen when the core tries to execute an instruction, and it comes with the faulting address. The second is an error on a data access, and it comes with the address of the next sequential instruction. An instruction error is reported only when execution is attempted. Fetch-time errors never reach this block.

When an interrupt is taken, one clock edge commits every affected register:
- the save-address register,
- the saved-state register,
- the masked machine state,
- the syndrome register,
- the redirected program counter.

A one-cycle redirect pulse marks that edge. The new program counter is the vector prefix followed by a fixed 0x0200 offset.

The syndrome flag for an instruction error is recorded even when machine checks are disabled. In that case no redirect happens. Turning the enable back on later never causes a deferred interrupt from that recorded flag. Software can overwrite the syndrome register through a write port.

Top module: `mck_sequencer`

## Requirements
- R1: After reset, `redirect`, `pc_new`, `srr2`, `srr3`, `msr_new` and `esr` are all zero.
- R2: An instruction error (`iex_err`) or a data error (`dac_err`) in a cycle where `msr_cur[12]` (the enable bit) is 1 produces `redirect`=1 in the next cycle. In that same cycle `pc_new` = {`vec_prefix`, 16'h0200}.
- R3: On a taken instruction error, `srr2` becomes the `iex_addr` of the error cycle. On a taken data error, `srr2` becomes `dac_nia`.
- R4: On a taken error, `srr3` becomes the `msr_cur` value of the error cycle.
- R5: On a taken error, `msr_new` becomes `msr_cur` with bits 18, 17, 15, 14, 13, 12, 11, 10, 9, 8, 5 and 4 cleared (mask 32'h0006FF30). All other bits are kept.
- R6: On a taken instruction error, `esr` becomes 32'h80000000. That is, the flag at bit 31 is set and every other bit is cleared.
- R7: An instruction error while `msr_cur[12]`=0 sets `esr[31]` and keeps the other `esr` bits. It produces no redirect. `pc_new`, `srr2`, `srr3` and `msr_new` keep their previous values.
- R8: Raising `msr_cur[12]` from 0 to 1 while `esr[31]` is already set produces no redirect unless a new error arrives.
- R9: A taken data error leaves `esr` unchanged. A data error while `msr_cur[12]`=0 changes no output.
- R10: When both errors arrive in the same cycle, the instruction error is the one taken. `srr2` gets `iex_addr` and the data error is dropped.
- R11: With `esr_wen`=1, `esr` takes `esr_wdata` in the next cycle. An instruction error in the same cycle still sets `esr[31]`, and that hardware set wins over the software value.
- R12: `redirect` is a single-cycle pulse. It is low in the cycle after a pulse unless a new error was taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iex_err | input | 1 | Bus error on an instruction whose execution is attempted |
| iex_addr | input | 32 | Address of the faulting instruction |
| dac_err | input | 1 | Error on a data access |
| dac_nia | input | 32 | Next sequential instruction address for a data error |
| msr_cur | input | 32 | Current machine state; bit 12 is the machine-check enable |
| vec_prefix | input | 16 | Vector prefix placed in the upper half of the target |
| esr_wen | input | 1 | Software write strobe for the syndrome register |
| esr_wdata | input | 32 | Software write data for the syndrome register |
| redirect | output | 1 | One-cycle pulse when an interrupt is taken |
| pc_new | output | 32 | Vector target, valid with `redirect` |
| srr2 | output | 32 | Saved return address |
| srr3 | output | 32 | Saved machine state |
| msr_new | output | 32 | Machine state with the interrupt fields cleared |
| esr | output | 32 | Syndrome register; bit 31 is the instruction machine-check flag |

## Verification
Every result is due exactly one clock edge after the cycle that carries the stimulus, because each output comes straight from a register. This holds for the redirect pulse, the vector, both save registers, the masked state and the syndrome value. The bench drives each stimulus on a falling edge, lets one rising edge pass, and samples all outputs on the following falling edge. It then clears the inputs before the next rising edge and samples once more to confirm that the pulse has dropped while the other values hold. Masked errors and a late raise of the enable bit are checked in the same cycle slot: the redirect must stay low there, and the earlier register values must still be present.

// File: rtl/mck_pkg.sv
package mck_pkg;

    localparam int XLEN = 32;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_INSN = 2'd1,
        SRC_DATA = 2'd2
    } mck_src_e;

    typedef struct packed {
        logic            redirect;
        logic [XLEN-1:0] pc;
        logic [XLEN-1:0] srr2;
        logic [XLEN-1:0] srr3;
        logic [XLEN-1:0] msr;
    } mck_regs_t;

endpackage

// File: rtl/mck_select.sv
module mck_select #(
    parameter int ME_BIT = 12,
    parameter int XLEN   = mck_pkg::XLEN
) (
    input  logic             iex_err,
    input  logic             dac_err,
    input  logic [XLEN-1:0]  msr_cur,
    output mck_pkg::mck_src_e src,
    output logic             take,
    output logic             mci_set
);
    import mck_pkg::*;

    logic enabled;

    always_comb begin
        enabled = msr_cur[ME_BIT];
        mci_set = iex_err;
        src     = SRC_NONE;
        if (enabled) begin
            if (iex_err) begin
                src = SRC_INSN;
            end else if (dac_err) begin
                src = SRC_DATA;
            end
        end
        take = (src != SRC_NONE);
    end

    // R10
    insn_wins_chk: assert final (!(iex_err && dac_err && enabled) || src == SRC_INSN);

endmodule

// File: rtl/mck_vector.sv
module mck_vector #(
    parameter int              XLEN     = mck_pkg::XLEN,
    parameter int              PFX_W    = 16,
    parameter logic [XLEN-1:0] CLR_MASK = 32'h0006_FF30,
    parameter logic [XLEN-PFX_W-1:0] VEC_OFS = 16'h0200
) (
    input  logic [PFX_W-1:0] vec_prefix,
    input  logic [XLEN-1:0]  msr_cur,
    output logic [XLEN-1:0]  vec_pc,
    output logic [XLEN-1:0]  msr_masked
);

    assign vec_pc = {vec_prefix, VEC_OFS};

    for (genvar i = 0; i < XLEN; i++) begin : g_bit
        if (CLR_MASK[i]) begin : g_clr
            assign msr_masked[i] = 1'b0;
        end else begin : g_keep
            assign msr_masked[i] = msr_cur[i];
        end
    end

endmodule

// File: rtl/mck_esr.sv
module mck_esr #(
    parameter int XLEN    = mck_pkg::XLEN,
    parameter int MCI_BIT = 31
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wen,
    input  logic [XLEN-1:0] wdata,
    input  logic            hw_set,
    input  logic            hw_take,
    output logic [XLEN-1:0] esr_q
);

    localparam logic [XLEN-1:0] MCI_ONLY = XLEN'(1) << MCI_BIT;

    logic [XLEN-1:0] esr_d;

    always_comb begin
        esr_d = esr_q;
        if (wen) begin
            esr_d = wdata;
        end
        if (hw_set) begin
            if (hw_take) begin
                esr_d = MCI_ONLY;
            end else begin
                esr_d = esr_d | MCI_ONLY;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            esr_q <= '0;
        end else begin
            esr_q <= esr_d;
        end
    end

    // R11
    set_beats_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_set && wen) |=> esr_q[MCI_BIT]);

    // R9
    esr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hw_set && !wen) |=> $stable(esr_q));

endmodule

// File: rtl/mck_sequencer.sv
module mck_sequencer #(
    parameter int              XLEN     = mck_pkg::XLEN,
    parameter int              PFX_W    = 16,
    parameter int              ME_BIT   = 12,
    parameter int              MCI_BIT  = 31,
    parameter logic [XLEN-1:0] CLR_MASK = 32'h0006_FF30,
    parameter logic [XLEN-PFX_W-1:0] VEC_OFS = 16'h0200
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             iex_err,
    input  logic [XLEN-1:0]  iex_addr,
    input  logic             dac_err,
    input  logic [XLEN-1:0]  dac_nia,
    input  logic [XLEN-1:0]  msr_cur,
    input  logic [PFX_W-1:0] vec_prefix,
    input  logic             esr_wen,
    input  logic [XLEN-1:0]  esr_wdata,
    output logic             redirect,
    output logic [XLEN-1:0]  pc_new,
    output logic [XLEN-1:0]  srr2,
    output logic [XLEN-1:0]  srr3,
    output logic [XLEN-1:0]  msr_new,
    output logic [XLEN-1:0]  esr
);
    import mck_pkg::*;

    mck_src_e        src;
    logic            take;
    logic            mci_set;
    logic [XLEN-1:0] vec_pc;
    logic [XLEN-1:0] msr_masked;
    mck_regs_t       regs_d;
    mck_regs_t       regs_q;

    mck_select #(.ME_BIT(ME_BIT), .XLEN(XLEN)) u_select (
        .iex_err (iex_err),
        .dac_err (dac_err),
        .msr_cur (msr_cur),
        .src     (src),
        .take    (take),
        .mci_set (mci_set)
    );

    mck_vector #(.XLEN(XLEN), .PFX_W(PFX_W), .CLR_MASK(CLR_MASK), .VEC_OFS(VEC_OFS)) u_vector (
        .vec_prefix (vec_prefix),
        .msr_cur    (msr_cur),
        .vec_pc     (vec_pc),
        .msr_masked (msr_masked)
    );

    mck_esr #(.XLEN(XLEN), .MCI_BIT(MCI_BIT)) u_esr (
        .clk     (clk),
        .rst_n   (rst_n),
        .wen     (esr_wen),
        .wdata   (esr_wdata),
        .hw_set  (mci_set),
        .hw_take (take),
        .esr_q   (esr)
    );

    always_comb begin
        regs_d          = regs_q;
        regs_d.redirect = 1'b0;
        if (take) begin
            regs_d.redirect = 1'b1;
            regs_d.pc       = vec_pc;
            regs_d.srr3     = msr_cur;
            regs_d.msr      = msr_masked;
            regs_d.srr2     = (src == SRC_INSN) ? iex_addr : dac_nia;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign redirect = regs_q.redirect;
    assign pc_new   = regs_q.pc;
    assign srr2     = regs_q.srr2;
    assign srr3     = regs_q.srr3;
    assign msr_new  = regs_q.msr;

    // R2
    insn_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (iex_err && msr_cur[ME_BIT]) |=> (redirect && srr2 == $past(iex_addr)));

    // R3
    data_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dac_err && !iex_err && msr_cur[ME_BIT]) |=> (redirect && srr2 == $past(dac_nia)));

    // R4
    state_saved_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((iex_err || dac_err) && msr_cur[ME_BIT]) |=> srr3 == $past(msr_cur));

    // R7
    masked_no_redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (iex_err && !msr_cur[ME_BIT]) |=> (!redirect && esr[MCI_BIT] && $stable(pc_new)));

    // R12
    no_spurious_redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!iex_err && !dac_err) |=> !redirect);

endmodule

// File: tb/sim_mck_sequencer.sv
module sim_mck_sequencer;

    localparam logic [31:0] MCI  = 32'h8000_0000;
    localparam logic [31:0] KEEP = 32'hFFF9_00CF;

    typedef struct packed {
        logic        ie;
        logic        de;
        logic [31:0] m;
        logic [31:0] ia;
        logic [31:0] na;
        logic [15:0] pfx;
        logic        exp_redir;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t TBL [NV] = '{
        '{1'b1, 1'b0, 32'h8006_FF31, 32'h1234_5678, 32'h0, 16'hABCD, 1'b1},
        '{1'b0, 1'b1, 32'hFFFF_FFFF, 32'h0, 32'h0000_4444, 16'h5555, 1'b1},
        '{1'b1, 1'b1, 32'h0000_1000, 32'hDEAD_BEE0, 32'h1111_1110, 16'hFFFF, 1'b1},
        '{1'b1, 1'b0, 32'hFFFF_EFFF, 32'hCAFE_0000, 32'h0, 16'h0101, 1'b0},
        '{1'b0, 1'b1, 32'h0000_0000, 32'h0, 32'h7777_0000, 16'h0202, 1'b0},
        '{1'b0, 1'b1, 32'h0000_1234, 32'h0, 32'h0000_0008, 16'h0000, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        iex_err = 1'b0;
    logic [31:0] iex_addr = '0;
    logic        dac_err = 1'b0;
    logic [31:0] dac_nia = '0;
    logic [31:0] msr_cur = '0;
    logic [15:0] vec_prefix = '0;
    logic        esr_wen = 1'b0;
    logic [31:0] esr_wdata = '0;
    logic        redirect;
    logic [31:0] pc_new, srr2, srr3, msr_new, esr;

    int checks = 0;
    int errors = 0;

    logic        e_redir = 1'b0;
    logic [31:0] e_pc = '0, e_srr2 = '0, e_srr3 = '0, e_msr = '0, e_esr = '0;

    always #4 clk = ~clk;

    mck_sequencer u0 (
        .clk(clk), .rst_n(rst_n),
        .iex_err(iex_err), .iex_addr(iex_addr),
        .dac_err(dac_err), .dac_nia(dac_nia),
        .msr_cur(msr_cur), .vec_prefix(vec_prefix),
        .esr_wen(esr_wen), .esr_wdata(esr_wdata),
        .redirect(redirect), .pc_new(pc_new), .srr2(srr2),
        .srr3(srr3), .msr_new(msr_new), .esr(esr)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic model(input logic ie, input logic de, input logic [31:0] m,
                         input logic [31:0] ia, input logic [31:0] na, input logic [15:0] pfx,
                         input logic we, input logic [31:0] wd);
        logic tk;
        tk = (ie || de) && m[12];
        e_redir = tk;
        if (we) e_esr = wd;
        if (ie) e_esr = tk ? MCI : (e_esr | MCI);
        if (tk) begin
            e_pc   = {pfx, 16'h0200};
            e_srr3 = m;
            e_msr  = m & KEEP;
            e_srr2 = ie ? ia : na;
        end
    endtask

    task automatic drive(input logic ie, input logic de, input logic [31:0] m,
                         input logic [31:0] ia, input logic [31:0] na, input logic [15:0] pfx,
                         input logic we, input logic [31:0] wd);
        @(negedge clk);
        iex_err = ie; dac_err = de; msr_cur = m; iex_addr = ia;
        dac_nia = na; vec_prefix = pfx; esr_wen = we; esr_wdata = wd;
        model(ie, de, m, ia, na, pfx, we, wd);
        @(negedge clk);
    endtask

    task automatic idle_inputs();
        iex_err = 1'b0; dac_err = 1'b0; esr_wen = 1'b0;
    endtask

    task automatic check_all();
        chk("R2", {31'd0, redirect}, {31'd0, e_redir});
        chk("R2", pc_new, e_pc);
        chk("R3", srr2, e_srr2);
        chk("R4", srr3, e_srr3);
        chk("R5", msr_new, e_msr);
        chk("R6", esr, e_esr);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual timeout expected finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", {31'd0, redirect}, 32'd0);
        chk("R1", pc_new | srr2 | srr3 | msr_new | esr, 32'd0);
        rst_n = 1'b1;

        // table walk
        for (int i = 0; i < NV; i++) begin
            drive(TBL[i].ie, TBL[i].de, TBL[i].m, TBL[i].ia, TBL[i].na, TBL[i].pfx, 1'b0, '0);
            idle_inputs();
            chk("R2", {31'd0, redirect}, {31'd0, TBL[i].exp_redir});
            check_all();
            if (TBL[i].ie && TBL[i].de) chk("R10", srr2, TBL[i].ia);
            @(negedge clk);
            // R12 pulse drops
            chk("R12", {31'd0, redirect}, 32'd0);
            chk("R9", esr, e_esr);
        end

        // R11 software write
        drive(1'b0, 1'b0, 32'h0, '0, '0, 16'h0, 1'b1, 32'h0000_00F0);
        idle_inputs();
        chk("R11", esr, 32'h0000_00F0);

        // R7 masked instruction error keeps other syndrome bits and registers
        drive(1'b1, 1'b0, 32'h0000_0000, 32'h4000_0000, '0, 16'h9999, 1'b0, '0);
        idle_inputs();
        chk("R7", esr, 32'h8000_00F0);
        chk("R7", {31'd0, redirect}, 32'd0);
        chk("R7", pc_new, e_pc);
        chk("R7", srr2, e_srr2);

        // R8 enable raised with flag pending, no new error
        drive(1'b0, 1'b0, 32'h0000_1000, '0, '0, 16'h0, 1'b0, '0);
        chk("R8", {31'd0, redirect}, 32'd0);
        @(negedge clk);
        chk("R8", {31'd0, redirect}, 32'd0);
        chk("R8", esr, 32'h8000_00F0);

        // R9 taken data error leaves syndrome alone
        drive(1'b0, 1'b1, 32'h0000_1000, '0, 32'h0000_0ABC, 16'h1357, 1'b0, '0);
        idle_inputs();
        chk("R9", {31'd0, redirect}, 32'd1);
        chk("R9", esr, 32'h8000_00F0);
        chk("R3", srr2, 32'h0000_0ABC);

        // R11 hardware set beats same-cycle software clear (masked)
        drive(1'b1, 1'b0, 32'h0000_0000, 32'h1, '0, 16'h0, 1'b1, 32'h0000_000F);
        idle_inputs();
        chk("R11", esr, 32'h8000_000F);

        // R11 software clear with taken error: only flag remains
        drive(1'b1, 1'b0, 32'h0000_1000, 32'h0000_0100, '0, 16'h2468, 1'b1, 32'h0);
        idle_inputs();
        chk("R11", esr, 32'h8000_0000);
        chk("R6", esr, e_esr);
        chk("R2", pc_new, 32'h2468_0200);

        // R11 plain clear
        drive(1'b0, 1'b0, 32'h0000_1000, '0, '0, 16'h0, 1'b1, 32'h0);
        idle_inputs();
        chk("R11", esr, 32'h0);
        check_all();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule